// File: doc/BRIEF.md
# Symmetric Half-Rate FIR Decimator

This block is a 21-tap linear-phase lowpass filter that halves the sample rate. Samples arrive as 21-bit signed words with a valid strobe. Every second accepted sample produces one filtered output. The output is rounded back to the 21-bit input format. When the result is out of range, the output clips at the positive or negative limit instead of wrapping.

The impulse response is even-symmetric about its centre tap, so only 11 coefficient registers exist. Coefficients are 16-bit signed fractions, with one sign bit and fifteen fraction bits. Mirrored samples are added first, and each sum then uses one shared coefficient. A plain address/data/write-enable port loads the coefficients while the filter is idle.

Decimation is controlled by a two-state machine:
- `PH_FIRST` waits for the first sample of a pair. Transition `take_first` moves it to `PH_SECOND` on an accepted sample.
- In `PH_SECOND`, transition `take_second` returns it to `PH_FIRST` on an accepted sample and fires an output.
- Without a valid sample, either state holds (`hold`).

Top module: `symfir_dec2`

## Requirements
- R1: While `rst` is high on a clock edge, the block clears the delay line, enters `PH_FIRST` and drives `out_valid` low and `out_data` to zero. Both outputs stay that way after reset is released until the first output fires.
- R2: Only cycles with `in_valid` high count as accepted samples. `out_valid` pulses for exactly one cycle, in the cycle after the edge that accepts the 2nd, 4th, 6th… sample since reset. Idle cycles neither advance the phase nor produce output.
- R3: Let w[0] be the sample accepted with the output and w[j] the sample accepted j samples earlier. Tap j uses coefficient min(j, 20−j).
- R4: Coefficient 10 is the centre tap and multiplies only w[10]. Coefficients 0 to 9 each multiply the pre-added sum w[j]+w[20−j].
- R5: The full-precision sum of products is rounded by adding 2^14 and shifting right arithmetically by 15. For example, with only coefficient 10 set to 1, a centre sample of 16384 gives 1, 16383 gives 0, −16384 gives 0, and −16385 gives −1.
- R6: Rounded results above 1048575 give 1048575 (0x0FFFFF). Results below −1048576 give −1048576 (0x100000).
- R7: A write with `cf_we` high and `cf_addr` from 0 to 10 stores `cf_data` into that coefficient at the clock edge. Writes to addresses 11 to 15 change no coefficient.
- R8: `out_data` holds its value in every cycle where `out_valid` is low.
- R9: Reset sets all coefficients to zero, so a filter that has not been loaded outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cf_we | input | 1 | Coefficient write enable |
| cf_addr | input | 4 | Coefficient index, 0 to 10 valid |
| cf_data | input | 16 | Signed 1.15 coefficient value |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 21 | Signed input sample |
| out_valid | output | 1 | One-cycle strobe for a new output |
| out_data | output | 21 | Rounded, saturated filtered sample |

## Verification
The bench drives an impulse through a distinct coefficient set and checks the reflected tap ordering. A design that swapped the mirror pairing, or that paired the centre tap with itself, would return wrong coefficients in the impulse outputs.

It inserts idle gaps inside and between sample pairs. A decimator that counted clock cycles instead of accepted samples would fire on the wrong sample or fire twice.

Rounding is probed exactly at the half-LSB points on both signs, where truncation or symmetric rounding would be off by one. Full-scale inputs of both signs with large coefficients check that the output clips to the limit. Writes to the unused addresses 11 to 15 are followed by an impulse run, which would expose an aliased coefficient.

// File: rtl/symfir_pkg.sv
package symfir_pkg;
    localparam int DEF_DATA_W = 21;
    localparam int DEF_COEF_W = 16;
    localparam int DEF_TAPS   = 21;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } dec_phase_e;
endpackage

// File: rtl/symfir_coef_bank.sv
module symfir_coef_bank #(
    parameter int CW    = 16,
    parameter int NUNIQ = 11,
    parameter int AW    = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic signed [CW-1:0] wr_data,
    output logic signed [CW-1:0] coef [NUNIQ]
);
    // Only indices below NUNIQ exist; higher addresses match no slot.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUNIQ; i++) begin
                coef[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < NUNIQ; i++) begin
                if (wr_addr == AW'(i)) begin
                    coef[i] <= wr_data;
                end
            end
        end
    end
endmodule

// File: rtl/symfir_delay_line.sv
module symfir_delay_line #(
    parameter int DW    = 21,
    parameter int DEPTH = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shift_en,
    input  logic signed [DW-1:0] din,
    output logic signed [DW-1:0] line [DEPTH]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                line[i] <= '0;
            end
        end else if (shift_en) begin
            line[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
                line[i] <= line[i-1];
            end
        end
    end
endmodule

// File: rtl/symfir_datapath.sv
module symfir_datapath #(
    parameter int DW    = 21,
    parameter int CW    = 16,
    parameter int NTAPS = 21
) (
    input  logic signed [DW-1:0] newest,
    input  logic signed [DW-1:0] line   [NTAPS-1],
    input  logic signed [CW-1:0] coef   [(NTAPS+1)/2],
    output logic signed [DW-1:0] result
);
    localparam int NUNIQ  = (NTAPS + 1) / 2;
    localparam int NPAIR  = NUNIQ - 1;
    localparam int SUM_W  = DW + 1;
    localparam int PROD_W = SUM_W + CW;
    localparam int GROW   = $clog2(NUNIQ + 1);
    localparam int ACC_W  = PROD_W + GROW;
    localparam int RW     = ACC_W + 1;
    localparam int FRAC   = CW - 1;

    localparam logic signed [RW-1:0] HALF = RW'(1) <<< (FRAC - 1);
    localparam logic signed [RW-1:0] MAXV = RW'((64'sd1 <<< (DW - 1)) - 64'sd1);
    localparam logic signed [RW-1:0] MINV = -MAXV - RW'(1);

    logic signed [DW-1:0]     win  [NTAPS];
    logic signed [PROD_W-1:0] prod [NUNIQ];
    logic signed [ACC_W-1:0]  acc;
    logic signed [RW-1:0]     rnd;
    logic signed [RW-1:0]     shifted;

    assign win[0] = newest;

    genvar g;
    generate
        for (g = 1; g < NTAPS; g++) begin : g_win
            assign win[g] = line[g-1];
        end

        for (g = 0; g < NPAIR; g++) begin : g_pair
            logic signed [SUM_W-1:0]  psum;
            logic signed [PROD_W-1:0] a_ext;
            logic signed [PROD_W-1:0] b_ext;
            assign psum  = SUM_W'(win[g]) + SUM_W'(win[NTAPS-1-g]);
            assign a_ext = PROD_W'(psum);
            assign b_ext = PROD_W'(coef[g]);
            assign prod[g] = a_ext * b_ext;
        end

        begin : g_centre
            logic signed [PROD_W-1:0] c_ext;
            logic signed [PROD_W-1:0] s_ext;
            assign s_ext = PROD_W'(win[NPAIR]);
            assign c_ext = PROD_W'(coef[NPAIR]);
            assign prod[NPAIR] = s_ext * c_ext;
        end
    endgenerate

    always_comb begin
        acc = '0;
        for (int i = 0; i < NUNIQ; i++) begin
            acc = acc + ACC_W'(prod[i]);
        end
        rnd     = RW'(acc) + HALF;
        shifted = rnd >>> FRAC;
        if (shifted > MAXV) begin
            result = DW'(MAXV);
        end else if (shifted < MINV) begin
            result = DW'(MINV);
        end else begin
            result = DW'(shifted);
        end
    end
endmodule

// File: rtl/symfir_phase_ctl.sv
module symfir_phase_ctl
    import symfir_pkg::*;
#(
    parameter int DW = 21
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] result,
    output dec_phase_e           phase,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_data
);
    dec_phase_e phase_nx;
    logic       fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FIRST;
        end else begin
            phase <= phase_nx;
        end
    end

    always_comb begin
        phase_nx = phase;
        fire     = 1'b0;
        unique case (phase)
            PH_FIRST: begin
                if (in_valid) begin
                    phase_nx = PH_SECOND;
                end
            end
            PH_SECOND: begin
                if (in_valid) begin
                    phase_nx = PH_FIRST;
                    fire     = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                out_data <= result;
            end
        end
    end
endmodule

// File: rtl/symfir_dec2.sv
module symfir_dec2
    import symfir_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int COEF_W = DEF_COEF_W,
    parameter int TAPS   = DEF_TAPS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cf_we,
    input  logic [3:0]        cf_addr,
    input  logic [COEF_W-1:0] cf_data,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int NUNIQ = (TAPS + 1) / 2;
    localparam int DEPTH = TAPS - 1;
    localparam int AW    = 4;

    logic signed [COEF_W-1:0] coef [NUNIQ];
    logic signed [DATA_W-1:0] line [DEPTH];
    logic signed [DATA_W-1:0] result;
    logic signed [DATA_W-1:0] out_s;
    logic [NUNIQ*COEF_W-1:0]  coef_flat;
    dec_phase_e               phase;
    logic                     ph_second;

    symfir_coef_bank #(.CW(COEF_W), .NUNIQ(NUNIQ), .AW(AW)) u_coef (
        .clk(clk), .rst(rst), .wr_en(cf_we), .wr_addr(cf_addr),
        .wr_data($signed(cf_data)), .coef(coef)
    );

    symfir_delay_line #(.DW(DATA_W), .DEPTH(DEPTH)) u_line (
        .clk(clk), .rst(rst), .shift_en(in_valid),
        .din($signed(in_data)), .line(line)
    );

    symfir_datapath #(.DW(DATA_W), .CW(COEF_W), .NTAPS(TAPS)) u_dp (
        .newest($signed(in_data)), .line(line), .coef(coef), .result(result)
    );

    symfir_phase_ctl #(.DW(DATA_W)) u_ctl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .result(result),
        .phase(phase), .out_valid(out_valid), .out_data(out_s)
    );

    assign out_data  = out_s;
    assign ph_second = (phase == PH_SECOND);

    genvar g;
    generate
        for (g = 0; g < NUNIQ; g++) begin : g_flat
            assign coef_flat[g*COEF_W +: COEF_W] = coef[g];
        end
    endgenerate
endmodule

// File: rtl/symfir_dec2_chk.sv
module symfir_dec2_chk #(
    parameter int DW    = 21,
    parameter int CW    = 16,
    parameter int NUNIQ = 11,
    parameter int AW    = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cf_we,
    input logic [AW-1:0]         cf_addr,
    input logic                  in_valid,
    input logic                  out_valid,
    input logic [DW-1:0]         out_data,
    input logic                  ph_second,
    input logic [NUNIQ*CW-1:0]   coef_flat
);
    // R1
    release_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && !ph_second && out_data == '0));

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R2
    idle_phase_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(ph_second));

    // R2
    pulse_needs_sample_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R7
    bad_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (cf_we && (32'(cf_addr) >= NUNIQ)) |=> $stable(coef_flat));

    // R8
    hold_data_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));
endmodule

bind symfir_dec2 symfir_dec2_chk #(
    .DW(DATA_W), .CW(COEF_W), .NUNIQ(NUNIQ), .AW(AW)
) u_chk (
    .clk(clk), .rst(rst), .cf_we(cf_we), .cf_addr(cf_addr),
    .in_valid(in_valid), .out_valid(out_valid), .out_data(out_data),
    .ph_second(ph_second), .coef_flat(coef_flat)
);

// File: tb/sim_symfir_dec2.sv
module sim_symfir_dec2;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cf_we = 1'b0;
    logic [3:0]  cf_addr = '0;
    logic [15:0] cf_data = '0;
    logic        in_valid = 1'b0;
    logic [20:0] in_data = '0;
    logic        out_valid;
    logic [20:0] out_data;

    int total = 0;
    int bad = 0;
    int mc [11];
    int ml [21];
    bit mph = 1'b0;
    int seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    symfir_dec2 u0 (
        .clk(clk), .rst(rst), .cf_we(cf_we), .cf_addr(cf_addr), .cf_data(cf_data),
        .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model_out();
        longint acc = 0;
        longint r;
        for (int k = 0; k < 10; k++) acc += longint'(mc[k]) * (longint'(ml[k]) + longint'(ml[20-k]));
        acc += longint'(mc[10]) * longint'(ml[10]);
        r = (acc + 64'sd16384) >>> 15;
        if (r > 1048575) r = 1048575;
        if (r < -1048576) r = -1048576;
        return r;
    endfunction

    function automatic longint dout();
        return longint'($signed(out_data));
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 21; i++) ml[i] = 0;
        for (int i = 0; i < 11; i++) mc[i] = 0;
        mph = 1'b0;
    endtask

    task automatic wr(input int addr, input int val);
        cf_we = 1'b1; cf_addr = 4'(addr); cf_data = 16'(val);
        @(negedge clk);
        cf_we = 1'b0;
        if (addr <= 10) mc[addr] = int'($signed(16'(val)));
    endtask

    task automatic push(input int x, input string req);
        longint e;
        in_valid = 1'b1; in_data = 21'(x);
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 20; i > 0; i--) ml[i] = ml[i-1];
        ml[0] = x;
        if (mph) begin
            e = model_out();
            chk(out_valid == 1'b1 && dout() == e, req, out_valid ? dout() : -999999, e);
        end else begin
            chk(out_valid == 1'b0, {req, " R2 no pulse"}, longint'(out_valid), 0);
        end
        mph = !mph;
    endtask

    task automatic idle(input int n);
        longint held;
        held = dout();
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R2 idle no pulse", longint'(out_valid), 0);
            chk(dout() == held, "R8 hold", dout(), held);
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0);
        chk(dout() == 0, "R1 data", dout(), 0);
        for (int i = 0; i < 8; i++) push(300000 - i * 77777, "R9 unloaded gives zero");
        chk(dout() == 0, "R9 zero output", dout(), 0);
    endtask

    task automatic load_set();
        for (int k = 0; k < 11; k++) wr(k, ((k % 2) ? -1 : 1) * (k + 1) * 1500);
    endtask

    task automatic t_impulse();
        do_reset();
        load_set();
        push(32768, "R3 impulse");
        for (int i = 0; i < 25; i++) push(0, "R3 R4 impulse tail");
        do_reset();
        load_set();
        push(0, "R3 shifted impulse");
        push(32768, "R3 shifted impulse");
        for (int i = 0; i < 24; i++) push(0, "R3 R4 shifted tail");
    endtask

    task automatic t_phase_gaps();
        do_reset();
        load_set();
        push(100000, "R2 first of pair");
        idle(5);
        push(-50000, "R2 second after gap");
        idle(3);
        push(7000, "R2 next pair first");
        push(9000, "R2 next pair second");
    endtask

    task automatic t_stream();
        do_reset();
        load_set();
        for (int i = 0; i < 200; i++) begin
            seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
            push(int'($signed(seed[18:0])), "R3 R4 stream");
            if (seed[22:21] == 2'b00) idle(int'(seed[25:24]) + 1);
        end
    endtask

    task automatic t_round_one(input int x, input longint e);
        do_reset();
        wr(10, 1);
        push(0, "R5 lead");
        push(x, "R5 centre sample");
        for (int i = 0; i < 10; i++) push(0, "R5 fill");
        chk(dout() == e, "R5 rounding point", dout(), e);
    endtask

    task automatic t_rounding();
        t_round_one(16384, 1);
        t_round_one(16383, 0);
        t_round_one(-16384, 0);
        t_round_one(-16385, -1);
    endtask

    task automatic t_saturate();
        do_reset();
        for (int k = 0; k < 11; k++) wr(k, 32767);
        for (int i = 0; i < 22; i++) push(1048575, "R6 positive clip");
        chk(dout() == 1048575, "R6 positive limit", dout(), 1048575);
        for (int i = 0; i < 22; i++) push(-1048576, "R6 negative clip");
        chk(dout() == -1048576, "R6 negative limit", dout(), -1048576);
    endtask

    task automatic t_bad_addr();
        do_reset();
        load_set();
        for (int a = 11; a < 16; a++) wr(a, 16'h7FFF);
        wr(10, -20000);
        push(32768, "R7 ignored writes impulse");
        for (int i = 0; i < 23; i++) push(0, "R7 ignored writes tail");
        chk(mc[10] == -20000, "R7 stored centre", mc[10], -20000);
    endtask

    initial begin
        t_reset_state();
        t_impulse();
        t_phase_gaps();
        t_stream();
        t_rounding();
        t_saturate();
        t_bad_addr();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule